// File: doc/BRIEF.md
# Split/Chained Capture Timer-Counter

This block is a timer/counter made of two byte-wide halves. A two-bit mode field decides whether the halves run on their own or are joined into one 16-bit unit. It also decides, for each half, whether that half counts ticks from a shared programmable prescaler or rising edges of an external event input. The event input and the two capture inputs are asynchronous. Each passes through a two-flop synchronizer and an edge detector before any logic uses it.

Each half, or the chained unit, counts up to a programmed match value. It holds there until its next count enable, then returns to zero and raises its interrupt flag. A rising edge on a capture input copies the count into a capture register. Software writes the match, prescale and control values through a small write port. It reads the counts and the capture registers through a combinational read port.

Top module: `ctm_timer`

## Requirements
- R1: While reset is asserted, both counts, both capture registers, both flags and the prescaler phase are zero. Reset also sets the prescale value to 0, both match values to all ones and the mode to 0.
- R2: The prescaler produces one tick every (P+1) clock cycles, where P is the value written at write address 2. A half clocked by the timer source advances by one on each tick and holds its count between ticks.
- R3: In mode 0 both halves count prescaler ticks on their own, each against its own match value (write address 0 for the low half, 1 for the high half).
- R4: In mode 1 the low half counts prescaler ticks. The high half counts only rising edges of `ev_in`, and each edge is counted once however long the input stays high. An edge is counted on the third clock after it is sampled.
- R5: In mode 2 the halves form one 16-bit count {high,low} that advances on prescaler ticks. The low half carries into the high half at all ones, and the count wraps against the 16-bit match value {match high, match low}.
- R6: In mode 3 the 16-bit chained count advances on each rising edge of `ev_in`.
- R7: A count that equals its match value returns to zero on its next count enable, and at that moment its flag is set. In modes 0 and 1 the low half sets `irq_lo` and the high half sets `irq_hi`. In modes 2 and 3 the chained wrap sets `irq_hi` only.
- R8: A write to address 3 takes bits [1:0] as the new mode. A one in bit 2 clears `irq_lo` and a one in bit 3 clears `irq_hi`. A flag being set in the same cycle as its clear stays set.
- R9: In modes 0 and 1 a rising edge on `cap_lo_in` copies the low count into the low capture register, and a rising edge on `cap_hi_in` copies the high count into the high capture register.
- R10: In modes 2 and 3 a rising edge on `cap_lo_in` copies all 16 bits into the two capture registers, and `cap_hi_in` has no effect.
- R11: A capture detected in the same cycle as a wrap stores the count held before the wrap (the match value), and the wrap still takes place.
- R12: Read address 0 returns the low count, 1 the high count, 2 the low capture register and 3 the high capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Write target: 0 match low, 1 match high, 2 prescale, 3 control |
| wr_data | input | HALF_W | Write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | HALF_W | Selected count or capture value |
| ev_in | input | 1 | Asynchronous external event input |
| cap_lo_in | input | 1 | Asynchronous low-half capture trigger |
| cap_hi_in | input | 1 | Asynchronous high-half capture trigger |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or chained match flag |

## Verification
The bench moves a capture pulse across every phase of a six-cycle wrap period, so one trigger lands exactly on the wrap. A design that captured after the update would store zero there instead of the match value. Event pulses of different widths, and one long high level, check that a design counting levels or both edges runs ahead of the reference. In the chained modes the match values are chosen so the low byte passes all ones several times, which exposes a missing or late carry. Driving `cap_hi_in` in those modes shows up any design that still lets it overwrite the high capture byte. Flag clears are issued while wraps are in progress, which catches a design where the clear wins over the set.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  typedef enum logic [1:0] {
    CTM_SPLIT_TT = 2'd0,
    CTM_SPLIT_TE = 2'd1,
    CTM_CHAIN_T  = 2'd2,
    CTM_CHAIN_E  = 2'd3
  } ctm_mode_e;

  typedef enum logic [1:0] {
    CTM_W_MATCH_LO = 2'd0,
    CTM_W_MATCH_HI = 2'd1,
    CTM_W_PRESCALE = 2'd2,
    CTM_W_CTRL     = 2'd3
  } ctm_waddr_e;

  typedef enum logic [1:0] {
    CTM_R_CNT_LO = 2'd0,
    CTM_R_CNT_HI = 2'd1,
    CTM_R_CAP_LO = 2'd2,
    CTM_R_CAP_HI = 2'd3
  } ctm_raddr_e;

  localparam int unsigned CTM_CLR_LO_BIT = 2;
  localparam int unsigned CTM_CLR_HI_BIT = 3;
  localparam int unsigned CTM_CTRL_USED  = 4;

  function automatic logic ctm_is_chained(input ctm_mode_e m);
    return (m == CTM_CHAIN_T) || (m == CTM_CHAIN_E);
  endfunction

  function automatic logic ctm_flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] divisor,
  output logic         tick
);

  logic [W-1:0] phase_q;

  function automatic logic at_limit(input logic [W-1:0] ph, input logic [W-1:0] lim);
    return ph >= lim;
  endfunction

  assign tick = at_limit(phase_q, divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-1:0], din};
    end
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/ctm_half.sv
module ctm_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wrap,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                               input logic inc_i, input logic wrap_i);
    if (wrap_i)     return '0;
    else if (inc_i) return cur + 1'b1;
    else            return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, inc, wrap);
  end

endmodule

// File: rtl/ctm_cap_reg.sv
module ctm_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] src,
  output logic [W-1:0] held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (fire) held <= src;
  end

endmodule

// File: rtl/ctm_timer.sv
module ctm_timer
  import ctm_pkg::*;
#(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  input  logic              ev_in,
  input  logic              cap_lo_in,
  input  logic              cap_hi_in,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int unsigned FULL_W = 2 * HALF_W;
  localparam int unsigned N_SYNC = 3;
  localparam int unsigned N_CAP  = 2;

  // programmable state
  logic [HALF_W-1:0] match_lo, match_hi, pre_div;
  ctm_mode_e         mode_q;

  logic wr_ctrl, clr_lo, clr_hi;
  assign wr_ctrl = wr_en && (ctm_waddr_e'(wr_addr) == CTM_W_CTRL);
  assign clr_lo  = wr_ctrl && wr_data[CTM_CLR_LO_BIT];
  assign clr_hi  = wr_ctrl && wr_data[CTM_CLR_HI_BIT];

  logic ctl_unused;
  assign ctl_unused = ^wr_data[HALF_W-1:CTM_CTRL_USED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_lo <= '1;
      match_hi <= '1;
      pre_div  <= '0;
      mode_q   <= CTM_SPLIT_TT;
    end else if (wr_en) begin
      case (ctm_waddr_e'(wr_addr))
        CTM_W_MATCH_LO: match_lo <= wr_data;
        CTM_W_MATCH_HI: match_hi <= wr_data;
        CTM_W_PRESCALE: pre_div  <= wr_data;
        default:        mode_q   <= ctm_mode_e'(wr_data[1:0]);
      endcase
    end
  end

  // tick source
  logic pre_tick;
  ctm_prescaler #(.W(HALF_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .divisor(pre_div), .tick(pre_tick)
  );

  // synchronizers: 0 = event, 1 = low capture, 2 = high capture
  logic [N_SYNC-1:0] raw_in, edge_p;
  assign raw_in = {cap_hi_in, cap_lo_in, ev_in};

  for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
    ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[gi]), .rise(edge_p[gi])
    );
  end

  logic ev_edge, cap_lo_edge, cap_hi_edge;
  assign ev_edge     = edge_p[0];
  assign cap_lo_edge = edge_p[1];
  assign cap_hi_edge = edge_p[2];

  // counting control
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic [FULL_W-1:0] cnt_full, match_full;
  logic chained, en_lo, en_hi, lo_at, hi_at, full_at;
  logic lo_inc, lo_wrap, hi_inc, hi_wrap, set_lo, set_hi;

  assign chained    = ctm_is_chained(mode_q);
  assign cnt_full   = {cnt_hi, cnt_lo};
  assign match_full = {match_hi, match_lo};
  assign lo_at      = (cnt_lo == match_lo);
  assign hi_at      = (cnt_hi == match_hi);
  assign full_at    = (cnt_full == match_full);

  always_comb begin
    en_lo = (mode_q == CTM_CHAIN_E) ? ev_edge : pre_tick;
    en_hi = (mode_q == CTM_SPLIT_TE) ? ev_edge : pre_tick;
    if (chained) begin
      lo_inc  = en_lo;
      lo_wrap = en_lo && full_at;
      hi_wrap = lo_wrap;
      hi_inc  = en_lo && (&cnt_lo);
      set_lo  = 1'b0;
      set_hi  = lo_wrap;
    end else begin
      lo_inc  = en_lo;
      lo_wrap = en_lo && lo_at;
      hi_inc  = en_hi;
      hi_wrap = en_hi && hi_at;
      set_lo  = lo_wrap;
      set_hi  = hi_wrap;
    end
  end

  ctm_half #(.W(HALF_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .inc(lo_inc), .wrap(lo_wrap), .cnt(cnt_lo)
  );
  ctm_half #(.W(HALF_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .inc(hi_inc), .wrap(hi_wrap), .cnt(cnt_hi)
  );

  // capture registers: 0 = low, 1 = high
  logic [N_CAP-1:0]  cap_fire;
  logic [HALF_W-1:0] cap_src  [N_CAP];
  logic [HALF_W-1:0] cap_held [N_CAP];
  logic [HALF_W-1:0] cap_lo_q, cap_hi_q;

  assign cap_fire[0] = cap_lo_edge;
  assign cap_fire[1] = chained ? cap_lo_edge : cap_hi_edge;
  assign cap_src[0]  = cnt_lo;
  assign cap_src[1]  = cnt_hi;

  for (genvar gc = 0; gc < N_CAP; gc++) begin : g_cap
    ctm_cap_reg #(.W(HALF_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .fire(cap_fire[gc]),
      .src(cap_src[gc]), .held(cap_held[gc])
    );
  end

  assign cap_lo_q = cap_held[0];
  assign cap_hi_q = cap_held[1];

  // flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= ctm_flag_next(irq_lo, set_lo, clr_lo);
      irq_hi <= ctm_flag_next(irq_hi, set_hi, clr_hi);
    end
  end

  // read port
  always_comb begin
    case (ctm_raddr_e'(rd_addr))
      CTM_R_CNT_LO: rd_data = cnt_lo;
      CTM_R_CNT_HI: rd_data = cnt_hi;
      CTM_R_CAP_LO: rd_data = cap_lo_q;
      default:      rd_data = cap_hi_q;
    endcase
  end

endmodule

// File: rtl/ctm_timer_chk.sv
module ctm_timer_chk #(
  parameter int unsigned HALF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_lo,
  input logic              set_lo,
  input logic              chained,
  input logic              lo_inc,
  input logic              lo_wrap,
  input logic              ev_edge,
  input logic              cap_lo_edge,
  input logic              cap_hi_edge,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic [HALF_W-1:0] cap_lo_q,
  input logic [HALF_W-1:0] cap_hi_q
);

  // R7: a wrap leaves the low count at zero
  p_wrap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (cnt_lo == '0));

  // R2: without an enable the low count holds
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_inc && !lo_wrap) |=> (cnt_lo == $past(cnt_lo)));

  // R7: the low flag rises only after a low wrap request
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> $past(set_lo));

  // R4: one edge pulse per rising edge
  p_event_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge |=> !ev_edge);

  // R5: carry from the low byte into the high byte
  p_chain_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && lo_inc && !lo_wrap && (&cnt_lo))
      |=> (cnt_lo == '0) && (cnt_hi == HALF_W'($past(cnt_hi) + 1'b1)));

  // R9: a low capture stores the pre-update low count
  p_cap_lo_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo_edge |=> (cap_lo_q == $past(cnt_lo)));

  // R10: high trigger alone is ignored when chained
  p_hi_trig_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && cap_hi_edge && !cap_lo_edge) |=> $stable(cap_hi_q));

endmodule

bind ctm_timer ctm_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lo(irq_lo), .set_lo(set_lo),
  .chained(chained), .lo_inc(lo_inc), .lo_wrap(lo_wrap), .ev_edge(ev_edge),
  .cap_lo_edge(cap_lo_edge), .cap_hi_edge(cap_hi_edge),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q)
);

// File: tb/ctm_timer_tb.sv
module ctm_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ev_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
  logic       irq_lo, irq_hi;

  always #5 clk = ~clk;

  ctm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in), .cap_lo_in(cap_lo_in),
    .cap_hi_in(cap_hi_in), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int    n_checks = 0, n_fail = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_phase, m_lo, m_hi, m_cap_lo, m_cap_hi, m_mlo, m_mhi, m_pre, m_mode;
  bit m_flo, m_fhi;
  int ev_hist[$], cl_hist[$], ch_hist[$];

  function automatic bit rose_seen(ref int h[$]);
    // h[0] newest sample; edge if sample two clocks old is 1 and three clocks old is 0
    return (h[1] == 1) && (h[2] == 0);
  endfunction

  task automatic model_reset();
    m_phase = 0; m_lo = 0; m_hi = 0; m_cap_lo = 0; m_cap_hi = 0;
    m_mlo = 255; m_mhi = 255; m_pre = 0; m_mode = 0; m_flo = 0; m_fhi = 0;
    ev_hist = '{0, 0, 0}; cl_hist = '{0, 0, 0}; ch_hist = '{0, 0, 0};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit tick, ev_r, cl_r, ch_r, en_a, en_b, set_a, set_b;
      int v, mv;
      tick = (m_phase >= m_pre);
      ev_r = rose_seen(ev_hist);
      cl_r = rose_seen(cl_hist);
      ch_r = rose_seen(ch_hist);
      set_a = 0; set_b = 0;
      m_phase = tick ? 0 : m_phase + 1;
      if (m_mode < 2) begin
        en_a = tick;
        en_b = (m_mode == 1) ? ev_r : tick;
        if (cl_r) m_cap_lo = m_lo;
        if (ch_r) m_cap_hi = m_hi;
        if (en_a) begin
          if (m_lo == m_mlo) begin m_lo = 0; set_a = 1; end
          else m_lo = (m_lo + 1) % 256;
        end
        if (en_b) begin
          if (m_hi == m_mhi) begin m_hi = 0; set_b = 1; end
          else m_hi = (m_hi + 1) % 256;
        end
      end else begin
        en_a = (m_mode == 3) ? ev_r : tick;
        v  = m_hi * 256 + m_lo;
        mv = m_mhi * 256 + m_mlo;
        if (cl_r) begin m_cap_lo = m_lo; m_cap_hi = m_hi; end
        if (en_a) begin
          if (v == mv) begin v = 0; set_b = 1; end
          else v = (v + 1) % 65536;
        end
        m_lo = v % 256;
        m_hi = v / 256;
      end
      if (wr_en && wr_addr == 2'd3) begin
        if (wr_data[2]) m_flo = 0;
        if (wr_data[3]) m_fhi = 0;
      end
      if (set_a) m_flo = 1;
      if (set_b) m_fhi = 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_mlo = wr_data;
          2'd1: m_mhi = wr_data;
          2'd2: m_pre = wr_data;
          default: m_mode = wr_data[1:0];
        endcase
      end
      ev_hist.push_front(ev_in);     void'(ev_hist.pop_back());
      cl_hist.push_front(cap_lo_in); void'(cl_hist.pop_back());
      ch_hist.push_front(cap_hi_in); void'(ch_hist.pop_back());
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge; R12 covers the read select
  always @(negedge clk) begin
    if (!done) begin
      int exp;
      case (rd_addr)
        2'd0: exp = m_lo;
        2'd1: exp = m_hi;
        2'd2: exp = m_cap_lo;
        default: exp = m_cap_hi;
      endcase
      check({cur_req, "/R12"}, rd_data, exp, $sformatf("rd_addr=%0d", rd_addr));
      check(cur_req, {30'd0, irq_hi, irq_lo}, {30'd0, m_fhi, m_flo}, "flags{hi,lo}");
      rd_addr <= rd_addr + 2'd1;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev_pulse(input int hi_cyc, input int lo_cyc);
    @(negedge clk); ev_in = 1'b1;
    idle(hi_cyc);   ev_in = 1'b0;
    idle(lo_cyc);
  endtask

  task automatic cap_pulse(input bit which_hi, input int gap);
    @(negedge clk);
    if (which_hi) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    @(negedge clk);
    cap_hi_in = 1'b0; cap_lo_in = 1'b0;
    idle(gap);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(6);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2";
    wr(2, 3); wr(0, 9); wr(1, 200);
    idle(120);

    cur_req = "R3";
    wr(2, 1); wr(0, 4); wr(1, 6);
    idle(150);

    cur_req = "R8";
    wr(3, 8'h04); idle(3);
    wr(3, 8'h08); idle(17);
    wr(3, 8'h0C); idle(30);

    cur_req = "R4";
    wr(3, 1); wr(1, 5); wr(2, 2);
    for (int i = 0; i < 14; i++) ev_pulse(1, (i % 4) + 1);
    ev_pulse(20, 4);
    for (int i = 0; i < 6; i++) ev_pulse((i % 3) + 1, 2);
    idle(10);

    cur_req = "R9";
    wr(3, 0); wr(2, 0); wr(0, 5); wr(1, 9);
    for (int i = 0; i < 14; i++) cap_pulse(i[0], (i % 7) + 3);

    cur_req = "R11";
    for (int i = 0; i < 12; i++) cap_pulse(1'b0, 5);
    idle(8);

    cur_req = "R5";
    wr(3, 2); wr(0, 8'h20); wr(1, 8'h01);
    idle(700);

    cur_req = "R10";
    for (int i = 0; i < 10; i++) begin
      cap_pulse(1'b1, 4);
      cap_pulse(i[0], 9);
    end

    cur_req = "R6";
    wr(3, 3); wr(0, 8'h05); wr(1, 8'h01);
    for (int i = 0; i < 600; i++) ev_pulse(1, 0);
    idle(6);

    cur_req = "R7";
    wr(3, 8'h0C); wr(2, 0); wr(0, 2); wr(1, 3);
    idle(40);
    for (int i = 0; i < 8; i++) begin
      wr(3, 8'h04); idle(i % 3);
      wr(3, 8'h08); idle(1);
    end
    idle(12);

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule